// File: doc/BRIEF.md
# Phase Lock Detector for a Digital PLL

This block decides whether a digital phase-locked loop has settled onto its selected input reference. It watches the signed phase-error samples produced by the loop's phase detector. Each sample is the phase difference between the input reference and the fed-back output clock. The block compares the magnitude of each sample against a programmable limit.

Time is divided into fixed monitoring windows. An external tick closes each window, nominally every 4 ms. A window counts as clean only when it contained at least one valid sample and no sample whose magnitude reached the limit. The lock status bit rises once a programmed number of consecutive clean windows has been seen. Any offending sample, any window without samples, and any change to the configuration drop lock at once and start the count again.

The block is meant to sit beside the loop filter. Its status bit feeds a status register or the reference-selection logic.

Top module: `phase_lock_detector`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it, `locked` is 0 and the clean-window count is zero.
- R2: The sample magnitude is the absolute value of `phase_err`, read as two's complement; the most negative code has magnitude 2^(PHASE_W-1). A sample is a violation when `phase_vld` is 1 and the magnitude is greater than or equal to `thr_cfg`, which is read as unsigned.
- R3: A window is clean only when it held at least one valid sample and no violation. A sample taken in the same cycle as `win_tick` belongs to the window that this tick closes.
- R4: Let N be `intv_cfg`, with the value 0 treated as 1. `locked` rises in the cycle after the `win_tick` that closes the N-th consecutive clean window.
- R5: A violation clears the clean-window count, and `locked` is 0 from the next cycle on.
- R6: A window with no valid sample is not clean: its closing tick clears the count, and `locked` is 0 in the next cycle.
- R7: Once set, `locked` stays 1 across further clean windows, and across cycles that have no tick, no violation and no configuration change.
- R8: In a cycle where `thr_cfg` or `intv_cfg` differs from its value in the previous cycle, the count is cleared, the open window is restarted, and `locked` is 0 in the next cycle. A sample or a tick in that cycle is ignored.
- R9: When `phase_vld` is 0, the value on `phase_err` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| phase_vld | input | 1 | Phase-error sample valid strobe |
| phase_err | input | PHASE_W | Signed (two's complement) phase-error sample |
| win_tick | input | 1 | One-cycle pulse that closes the current monitoring window |
| thr_cfg | input | PHASE_W | Unsigned magnitude limit |
| intv_cfg | input | INTV_W | Number of consecutive clean windows required for lock (0 acts as 1) |
| locked | output | 1 | Lock status |

## Verification
The comparison is driven with small random errors of both signs, which settle lock. It is then driven with samples exactly at the limit, positive and negative, which show whether the comparison includes equality and uses the absolute value. The most negative code is tried against limits just above and at its magnitude, to expose an overflowing absolute value. Windows made only of invalid large values, windows with a single sample in the tick cycle, and windows with no samples separate "no valid data" from "data in the closing cycle". A long random run then mixes window lengths, violations, empty windows and configuration writes, some of them coinciding with ticks.

// File: rtl/plld_pkg.sv
// Package: shared types for the phase lock detector.
// Assumes: nothing beyond standard SystemVerilog.
package plld_pkg;

    // Outcome of one monitoring window, reported in the cycle of its tick.
    typedef struct packed {
        logic closed;     // a window closes this cycle
        logic qualified;  // the closing window was clean
    } win_verdict_t;

endpackage

// File: rtl/plld_mag_cmp.sv
// Module: plld_mag_cmp
// Forms the magnitude of a signed phase-error sample and flags a violation
// when a valid sample reaches the unsigned limit.
// Assumes: phase_err is two's complement; the most negative code yields
// 2^(PHASE_W-1), which fits in PHASE_W unsigned bits.
module plld_mag_cmp #(
    parameter int PHASE_W = 16
) (
    input  logic               phase_vld,
    input  logic [PHASE_W-1:0] phase_err,
    input  logic [PHASE_W-1:0] thr_cfg,
    output logic               viol
);

    logic [PHASE_W-1:0] mag;

    // Absolute value of the sample, read as unsigned.
    always_comb begin
        if (phase_err[PHASE_W-1]) begin
            mag = ~phase_err + {{(PHASE_W-1){1'b0}}, 1'b1};
        end else begin
            mag = phase_err;
        end
    end

    // A valid sample at or above the limit is a violation.
    always_comb begin
        viol = phase_vld && (mag >= thr_cfg);
    end

endmodule

// File: rtl/plld_cfg_watch.sv
// Module: plld_cfg_watch
// Keeps the previous configuration, flags any change, and derives the
// required window count, with zero treated as one.
// Assumes: configuration inputs are synchronous to clk.
module plld_cfg_watch #(
    parameter int PHASE_W = 16,
    parameter int INTV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PHASE_W-1:0] thr_cfg,
    input  logic [INTV_W-1:0] intv_cfg,
    output logic              cfg_chg,
    output logic [INTV_W-1:0] target
);

    logic [PHASE_W-1:0] thr_q;
    logic [INTV_W-1:0]  intv_q;

    // Capture the configuration every cycle, including during reset.
    always_ff @(posedge clk) begin
        thr_q  <= thr_cfg;
        intv_q <= intv_cfg;
    end

    // A change is any difference from the previous cycle, outside reset.
    always_comb begin
        cfg_chg = rst_n && ((thr_cfg != thr_q) || (intv_cfg != intv_q));
    end

    // The required count: a programmed zero acts as one.
    always_comb begin
        if (intv_cfg == '0) begin
            target = {{(INTV_W-1){1'b0}}, 1'b1};
        end else begin
            target = intv_cfg;
        end
    end

endmodule

// File: rtl/plld_window_acc.sv
// Module: plld_window_acc
// Tracks whether the open window has seen a valid sample and whether it
// has seen a violation, and reports the verdict when the tick closes it.
// Assumes: a sample in the tick cycle belongs to the closing window; clr
// restarts the window and suppresses a coincident tick.
module plld_window_acc
    import plld_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         phase_vld,
    input  logic         viol,
    input  logic         win_tick,
    output win_verdict_t verdict
);

    logic seen_q;
    logic bad_q;

    // Verdict of the closing window, including the sample of this cycle.
    always_comb begin
        verdict.closed    = win_tick && !clr;
        verdict.qualified = (seen_q || phase_vld) && !(bad_q || viol);
    end

    // Collect evidence for the open window; restart it on tick or clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || win_tick) begin
            seen_q <= 1'b0;
            bad_q  <= 1'b0;
        end else begin
            seen_q <= seen_q || phase_vld;
            bad_q  <= bad_q || viol;
        end
    end

endmodule

// File: rtl/plld_qual_counter.sv
// Module: plld_qual_counter
// Counts consecutive clean windows, saturating at the target, and keeps
// the lock status.
// Assumes: target is never zero; clr has priority over everything else.
module plld_qual_counter
    import plld_pkg::*;
#(
    parameter int INTV_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              viol,
    input  win_verdict_t      verdict,
    input  logic [INTV_W-1:0] target,
    output logic              locked
);

    localparam int CW = INTV_W + 1;

    logic [INTV_W-1:0] cnt_q;
    logic [CW-1:0]     cnt_inc;
    logic              reached;

    // The count after one more clean window, and whether it meets the target.
    always_comb begin
        cnt_inc = {1'b0, cnt_q} + {{INTV_W{1'b0}}, 1'b1};
        reached = cnt_inc >= {1'b0, target};
    end

    // Update the count and the lock status on window close and violations.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q  <= '0;
            locked <= 1'b0;
        end else if (verdict.closed) begin
            if (verdict.qualified) begin
                cnt_q  <= reached ? target : cnt_inc[INTV_W-1:0];
                locked <= reached;
            end else begin
                cnt_q  <= '0;
                locked <= 1'b0;
            end
        end else if (viol) begin
            cnt_q  <= '0;
            locked <= 1'b0;
        end
    end

endmodule

// File: rtl/phase_lock_detector.sv
// Module: phase_lock_detector
// Declares lock once the phase-error magnitude has stayed below a limit for
// a programmed number of consecutive monitoring windows.
// Assumes: win_tick is a one-cycle pulse per window; all inputs are
// synchronous to clk; reset is synchronous and active low.
module phase_lock_detector
    import plld_pkg::*;
#(
    parameter int PHASE_W = 16,
    parameter int INTV_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               phase_vld,
    input  logic [PHASE_W-1:0] phase_err,
    input  logic               win_tick,
    input  logic [PHASE_W-1:0] thr_cfg,
    input  logic [INTV_W-1:0]  intv_cfg,
    output logic               locked
);

    logic              viol;
    logic              cfg_chg;
    logic [INTV_W-1:0] target;
    win_verdict_t      verdict;

    plld_mag_cmp #(.PHASE_W(PHASE_W)) mag_i (
        .phase_vld (phase_vld),
        .phase_err (phase_err),
        .thr_cfg   (thr_cfg),
        .viol      (viol)
    );

    plld_cfg_watch #(.PHASE_W(PHASE_W), .INTV_W(INTV_W)) cfg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .thr_cfg  (thr_cfg),
        .intv_cfg (intv_cfg),
        .cfg_chg  (cfg_chg),
        .target   (target)
    );

    plld_window_acc win_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (cfg_chg),
        .phase_vld (phase_vld),
        .viol      (viol),
        .win_tick  (win_tick),
        .verdict   (verdict)
    );

    plld_qual_counter #(.INTV_W(INTV_W)) cnt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (cfg_chg),
        .viol    (viol),
        .verdict (verdict),
        .target  (target),
        .locked  (locked)
    );

endmodule

// File: rtl/plld_checker.sv
// Module: plld_checker
// Temporal properties on the ports of the phase lock detector.
// Assumes: bound to phase_lock_detector with matching parameters.
module plld_checker #(
    parameter int PHASE_W = 16,
    parameter int INTV_W  = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               phase_vld,
    input logic [PHASE_W-1:0] phase_err,
    input logic               win_tick,
    input logic [PHASE_W-1:0] thr_cfg,
    input logic [INTV_W-1:0]  intv_cfg,
    input logic               locked
);

    logic [PHASE_W:0] abs_c;
    logic             bad_c;

    // Independent magnitude, one bit wider, for the violation condition.
    always_comb begin
        if (phase_err[PHASE_W-1]) begin
            abs_c = {1'b0, ~phase_err} + {{PHASE_W{1'b0}}, 1'b1};
        end else begin
            abs_c = {1'b0, phase_err};
        end
        bad_c = phase_vld && (abs_c >= {1'b0, thr_cfg});
    end

    // R1: the status is low on the first cycle after reset.
    assert_reset_clear_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> !locked);

    // R4: lock only rises after a window tick.
    assert_rise_after_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(win_tick));

    // R5: a violating sample drops lock in the next cycle.
    assert_viol_unlock_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bad_c |=> !locked);

    // R8: a configuration change drops lock in the next cycle.
    assert_cfg_unlock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_cfg != $past(thr_cfg) || intv_cfg != $past(intv_cfg)) |=> !locked);

    // R7: without a tick, a violation or a change, lock is held.
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !win_tick && !bad_c && thr_cfg == $past(thr_cfg)
         && intv_cfg == $past(intv_cfg)) |=> locked);

endmodule

bind phase_lock_detector plld_checker #(.PHASE_W(PHASE_W), .INTV_W(INTV_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase_vld (phase_vld),
    .phase_err (phase_err),
    .win_tick  (win_tick),
    .thr_cfg   (thr_cfg),
    .intv_cfg  (intv_cfg),
    .locked    (locked)
);

// File: tb/phase_lock_detector_tb_top.sv
// Bench: behavioural reference model compared with the design on every clock.
module phase_lock_detector_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int PHASE_W    = 16;
    localparam int INTV_W     = 8;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               phase_vld = 1'b0;
    logic [PHASE_W-1:0] phase_err = '0;
    logic               win_tick = 1'b0;
    logic [PHASE_W-1:0] thr_cfg = 16'd100;
    logic [INTV_W-1:0]  intv_cfg = 8'd3;
    logic               locked;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    // Reference model state.
    int m_thr, m_intv, m_cnt;
    bit m_seen, m_bad, m_lock;

    phase_lock_detector #(.PHASE_W(PHASE_W), .INTV_W(INTV_W)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase_vld (phase_vld),
        .phase_err (phase_err),
        .win_tick  (win_tick),
        .thr_cfg   (thr_cfg),
        .intv_cfg  (intv_cfg),
        .locked    (locked)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int mag_of(logic [PHASE_W-1:0] e);
        int v;
        v = int'($signed(e));
        return (v < 0) ? -v : v;
    endfunction

    // Behavioural model of the requirements, one step per rising edge.
    always @(posedge clk) begin : model
        int  tgt;
        bit  viol;
        bit  q;
        if (!rst_n) begin
            m_thr = int'(thr_cfg); m_intv = int'(intv_cfg);
            m_cnt = 0; m_seen = 0; m_bad = 0; m_lock = 0;
        end else if (int'(thr_cfg) != m_thr || int'(intv_cfg) != m_intv) begin
            m_thr = int'(thr_cfg); m_intv = int'(intv_cfg);
            m_cnt = 0; m_seen = 0; m_bad = 0; m_lock = 0;
        end else begin
            tgt  = (m_intv == 0) ? 1 : m_intv;
            viol = phase_vld && (mag_of(phase_err) >= m_thr);
            if (win_tick) begin
                q = (m_seen || phase_vld) && !(m_bad || viol);
                if (q) begin
                    m_cnt  = (m_cnt + 1 > tgt) ? tgt : m_cnt + 1;
                    m_lock = (m_cnt == tgt);
                end else begin
                    m_cnt = 0; m_lock = 0;
                end
                m_seen = 0; m_bad = 0;
            end else begin
                if (viol) begin m_cnt = 0; m_lock = 0; end
                m_seen = m_seen || phase_vld;
                m_bad  = m_bad || viol;
            end
        end
    end

    // Advance one clock and compare the design with the model.
    task automatic step();
        @(negedge clk);
        checks++;
        if (locked !== m_lock) begin
            errors++;
            $display("FAIL %s: locked=%0b expected=%0b at %0t", cur_req, locked, m_lock, $time);
        end
    endtask

    // Compare the design with a value worked out from the requirements.
    task automatic expect_lock(bit exp, string req);
        checks++;
        if (locked !== exp) begin
            errors++;
            $display("FAIL %s: locked=%0b expected=%0b at %0t", req, locked, exp, $time);
        end
    endtask

    // One window: len cycles, tick on the last, small random samples.
    // bad_pos >= 0 puts bad_val there; empty drops every strobe;
    // noisy invalidates odd cycles with a huge value; tick_only samples only at the tick.
    task automatic window(int len, int amp, int bad_pos, logic [PHASE_W-1:0] bad_val,
                          bit empty, bit noisy, bit tick_only);
        for (int i = 0; i < len; i++) begin
            int r;
            r = int'($urandom_range(2 * amp)) - amp;
            win_tick  = (i == len - 1);
            phase_vld = !empty;
            phase_err = PHASE_W'(r);
            if (noisy && (i % 2 == 1)) begin
                phase_vld = 1'b0;
                phase_err = 16'h7FFF;
            end
            if (tick_only && i != len - 1) phase_vld = 1'b0;
            if (i == bad_pos) begin
                phase_vld = 1'b1;
                phase_err = bad_val;
            end
            step();
        end
        win_tick  = 1'b0;
        phase_vld = 1'b0;
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state.
        cur_req = "R1";
        repeat (3) step();
        expect_lock(1'b0, "R1");
        rst_n = 1'b1;
        step();
        expect_lock(1'b0, "R1");

        // R4: three clean windows with limit 100.
        cur_req = "R4";
        window(8, 60, -1, '0, 0, 0, 0);
        window(8, 60, -1, '0, 0, 0, 0);
        expect_lock(1'b0, "R4");
        window(8, 60, -1, '0, 0, 0, 0);
        expect_lock(1'b1, "R4");

        // R7: further clean windows keep lock.
        cur_req = "R7";
        window(8, 60, -1, '0, 0, 0, 0);
        window(8, 60, -1, '0, 0, 0, 0);
        expect_lock(1'b1, "R7");

        // R5 and R2: a sample exactly at +100 drops lock the next cycle.
        cur_req = "R5";
        phase_vld = 1'b1; phase_err = 16'd100;
        step();
        phase_vld = 1'b0;
        expect_lock(1'b0, "R5");
        window(8, 60, -1, '0, 0, 0, 0);
        expect_lock(1'b0, "R5");
        window(8, 60, -1, '0, 0, 0, 0);
        window(8, 60, -1, '0, 0, 0, 0);
        window(8, 60, -1, '0, 0, 0, 0);
        expect_lock(1'b1, "R5");

        // R2: -99 is below the limit, -100 reaches it.
        cur_req = "R2";
        window(8, 10, 3, -16'sd99, 0, 0, 0);
        expect_lock(1'b1, "R2");
        window(8, 10, 3, -16'sd100, 0, 0, 0);
        expect_lock(1'b0, "R2");

        // R9: invalid huge values between clean samples have no effect.
        cur_req = "R9";
        repeat (3) window(8, 60, -1, '0, 0, 1, 0);
        expect_lock(1'b1, "R9");

        // R6: a window with no samples drops lock.
        cur_req = "R6";
        window(8, 60, -1, '0, 1, 0, 0);
        expect_lock(1'b0, "R6");

        // R8 and R2: limit at full scale, most negative code is below it.
        cur_req = "R8";
        thr_cfg = 16'hFFFF;
        step();
        expect_lock(1'b0, "R8");
        cur_req = "R2";
        repeat (3) window(6, 0, 2, 16'h8000, 0, 0, 0);
        expect_lock(1'b1, "R2");
        // Limit equal to the magnitude of the most negative code.
        thr_cfg = 16'h8000;
        step();
        repeat (3) window(6, 0, 2, 16'h8000, 0, 0, 0);
        expect_lock(1'b0, "R2");
        thr_cfg = 16'h8001;
        step();
        repeat (3) window(6, 0, 2, 16'h8000, 0, 0, 0);
        expect_lock(1'b1, "R2");

        // R4: zero interval acts as one; R3: only sample is in the tick cycle.
        cur_req = "R3";
        thr_cfg = 16'd100; intv_cfg = 8'd0;
        step();
        window(5, 10, -1, '0, 0, 0, 1);
        expect_lock(1'b1, "R3");
        window(5, 10, 4, 16'd200, 0, 0, 0);
        expect_lock(1'b0, "R3");
        window(5, 10, -1, '0, 0, 0, 0);
        expect_lock(1'b1, "R4");

        // R8: a tick coinciding with a configuration change is ignored.
        cur_req = "R8";
        window(5, 10, -1, '0, 0, 0, 0);
        phase_vld = 1'b1; phase_err = 16'd5; win_tick = 1'b1; intv_cfg = 8'd1;
        step();
        win_tick = 1'b0; phase_vld = 1'b0;
        expect_lock(1'b0, "R8");
        window(5, 10, -1, '0, 0, 0, 0);
        expect_lock(1'b1, "R8");

        // Mixed random run compared with the model every clock.
        cur_req = "R7";
        thr_cfg = 16'd200; intv_cfg = 8'd2;
        for (int k = 0; k < 400; k++) begin
            int sel;
            sel = int'($urandom_range(19));
            if (sel == 0) begin
                cur_req = "R8";
                thr_cfg  = 16'(150 + $urandom_range(100));
                intv_cfg = 8'($urandom_range(4));
            end
            if (sel == 1) begin
                cur_req = "R6";
                window(int'($urandom_range(2, 12)), 100, -1, '0, 1, 0, 0);
            end else if (sel == 2) begin
                cur_req = "R5";
                window(int'($urandom_range(2, 12)), 100, int'($urandom_range(1)), 16'hFF00, 0, 0, 0);
            end else begin
                cur_req = "R3";
                window(int'($urandom_range(1, 12)), 140, -1, '0, 0, sel > 15, sel == 3);
            end
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule